// File: doc/BRIEF.md
# Indirect Dword Register Access Window

This block is a small capability in configuration space that gives indirect access to a much larger controller register file. Software writes a dword index into a select byte, then reads or writes a 32-bit data word that stands for the register file dword at byte address index×4. The data word is a live mirror of the selected register. Every configuration write that touches the capability, including one that only changes the select byte, triggers a refresh of the mirror from the register file.

The block sits between a dword-addressed configuration write/read interface with byte enables and a single register file port. The port has a write strobe with byte lanes and a read strobe with one cycle of read latency. A sequencer with five states runs each access:
- `ST_IDLE` accepts a write.
- `ST_FWD` forwards the data word.
- `ST_RFRESH` issues the refresh read.
- `ST_LOAD` captures the returned word.
- `ST_ZFILL` clears the mirror when the select points past the register file.

The transitions are:
- `ST_IDLE`→`ST_FWD` on an accepted write with a data lane.
- `ST_IDLE`→`ST_RFRESH` on an accepted write without one.
- `ST_FWD`→`ST_RFRESH` when the select is in range.
- `ST_FWD`→`ST_ZFILL` when it is not.
- `ST_RFRESH`→`ST_LOAD` when the select is in range.
- `ST_RFRESH`→`ST_ZFILL` when it is not.
- `ST_LOAD`→`ST_IDLE` and `ST_ZFILL`→`ST_IDLE` unconditionally.

The capability occupies two dwords at dword index `CAP_DW`. In the first dword, byte 0 is the capability ID, byte 1 is the next pointer, byte 2 is the select and byte 3 is the pending/status byte. The second dword holds the data word.

Top module: `iwin_dword_window`

## Requirements
- R1: After reset the select is 0, the data word is 0, the status byte (byte 3 of dword `CAP_DW`) is 0, `busy` is low and neither register file strobe is active.
- R2: Bytes 0 and 1 of dword `CAP_DW` read back as `CAP_ID` and `NEXT_PTR`, and byte 3 reads 0. Writes to these three bytes change none of them.
- R3: A write to dword `CAP_DW` with byte enable 2 set loads the select from write data bits 23:16.
- R4: A write to dword `CAP_DW+1` merges the enabled bytes into the data word. In the cycle after the write is accepted, the merged 32-bit word is driven on `rf_wr_data` with `rf_wr_en` high and `rf_addr` equal to select×4.
- R5: The refresh read strobe `rf_rd_en` is issued in the cycle after the forwarded write. The mirror then holds the word the register file returns, including any change the register file made to the written value.
- R6: An accepted write that has no byte enable on the data dword issues no register file write. It issues the refresh read in the next cycle and updates the mirror.
- R7: A write to any other dword, or a write with all byte enables clear, is ignored. No strobe is issued and the select and data word are unchanged.
- R8: When select×4 ≥ `RF_BYTES`, no register file write or read is issued and the data word becomes 0.
- R9: For a dword that extends past `RF_BYTES`, only the lanes below `RF_BYTES` are enabled on `rf_wr_be`. Lanes past the end read as 0 in the mirror.
- R10: `busy` rises in the cycle after an accepted write and falls once the mirror has been updated. Configuration writes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | Configuration dword index of the write |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | CFG_AW | Configuration dword index to read |
| cfg_rd_data | output | 32 | Read data for `cfg_rd_addr` (0 outside the capability) |
| busy | output | 1 | A forward/refresh sequence is in progress |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_rd_en | output | 1 | Register file read strobe; data returns one cycle later |
| rf_addr | output | SEL_W+2 | Register file byte address (select×4) |
| rf_wr_be | output | 4 | Register file write byte lanes, clipped at the file end |
| rf_wr_data | output | 32 | Forwarded data word |
| rf_rd_data | input | 32 | Register file read data |

## Verification
The hardest situation to reach is a refresh that returns something other than what was just written. The bench's register file model clears a bit of one byte whenever that byte is written. Writing a word that sets this bit, and then reading the mirror, shows whether the mirror came from the register file or from the local copy. Dwords that straddle or lie past the end of the file are reached by steering the select to the last partial dword and then beyond it. The model answers bytes past its end with a non-zero filler, so any missing clip becomes visible in the mirror.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

    localparam int DW_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD,
        ST_RFRESH,
        ST_LOAD,
        ST_ZFILL
    } win_state_t;

    // Expand a per-byte lane mask into a 32-bit bit mask.
    function automatic logic [31:0] lane_bits(input logic [DW_BYTES-1:0] lanes);
        logic [31:0] m;
        for (int i = 0; i < DW_BYTES; i++) begin
            m[i*8 +: 8] = {8{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/iwin_range.sv
module iwin_range
    import iwin_pkg::*;
#(
    parameter int SEL_W    = 8,
    parameter int RF_BYTES = 150
) (
    input  logic [SEL_W-1:0]    sel,
    output logic [SEL_W+1:0]    byte_addr,
    output logic                in_range,
    output logic [DW_BYTES-1:0] lane_ok
);
    localparam int AW = SEL_W + 2;

    assign byte_addr = {sel, 2'b00};
    assign in_range  = int'(byte_addr) < RF_BYTES;

    for (genvar g = 0; g < DW_BYTES; g++) begin : g_lane
        assign lane_ok[g] = (int'(byte_addr) + g) < RF_BYTES;
    end

    // The lowest lane of any in-range dword must exist.
    always_comb begin
        assert_low_lane_R9: assert (!in_range || lane_ok[0]);
    end

    logic unused_aw;
    assign unused_aw = (AW == 0);

endmodule

// File: rtl/iwin_seq.sv
module iwin_seq
    import iwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic data_hit,
    input  logic in_range,
    output logic busy,
    output logic rf_wr_en,
    output logic rf_rd_en,
    output logic load_en,
    output logic zero_en
);
    win_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = data_hit ? ST_FWD : ST_RFRESH;
            ST_FWD:    state_d = in_range ? ST_RFRESH : ST_ZFILL;
            ST_RFRESH: state_d = in_range ? ST_LOAD : ST_ZFILL;
            ST_LOAD:   state_d = ST_IDLE;
            ST_ZFILL:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = 1'b1;
        rf_wr_en = 1'b0;
        rf_rd_en = 1'b0;
        load_en  = 1'b0;
        zero_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_FWD:    rf_wr_en = in_range;
            ST_RFRESH: rf_rd_en = in_range;
            ST_LOAD:   load_en = 1'b1;
            ST_ZFILL:  zero_en = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    assert_sel_only_no_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !data_hit) |=> !rf_wr_en);

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en || zero_en) |=> !busy);

endmodule

// File: rtl/iwin_regs.sv
module iwin_regs
    import iwin_pkg::*;
#(
    parameter int       SEL_W    = 8,
    parameter int       CFG_AW   = 6,
    parameter int       CAP_DW   = 16,
    parameter bit [7:0] CAP_ID   = 8'h0C,
    parameter bit [7:0] NEXT_PTR = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_req,
    input  logic                wr_hit,
    input  logic                busy,
    input  logic                accept,
    input  logic                wr_data_dw,
    input  logic [DW_BYTES-1:0] wr_be,
    input  logic [31:0]         wr_data,
    input  logic                load_en,
    input  logic                zero_en,
    input  logic [31:0]         load_word,
    input  logic [DW_BYTES-1:0] lane_ok,
    input  logic [CFG_AW-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    output logic [SEL_W-1:0]    sel_q,
    output logic [31:0]         data_q
);
    localparam logic [CFG_AW-1:0] HDR_IDX  = CFG_AW'(CAP_DW);
    localparam logic [CFG_AW-1:0] DATA_IDX = CFG_AW'(CAP_DW + 1);
    localparam int                SEL_LANE = 2;

    logic [31:0] merged;

    for (genvar g = 0; g < DW_BYTES; g++) begin : g_merge
        assign merged[g*8 +: 8] = wr_be[g] ? wr_data[g*8 +: 8] : data_q[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            if (wr_data_dw)          data_q <= merged;
            else if (wr_be[SEL_LANE]) sel_q <= wr_data[SEL_LANE*8 +: SEL_W];
        end else if (load_en) begin
            data_q <= load_word & lane_bits(lane_ok);
        end else if (zero_en) begin
            data_q <= '0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == HDR_IDX)
            rd_data = {8'h00, 8'(sel_q), NEXT_PTR, CAP_ID};
        else if (rd_addr == DATA_IDX)
            rd_data = data_q;
    end

    assert_ignored_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_hit && !busy) |=> ($stable(sel_q) && $stable(data_q)));

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && busy) |=> $stable(sel_q));

endmodule

// File: rtl/iwin_dword_window.sv
module iwin_dword_window
    import iwin_pkg::*;
#(
    parameter int       CFG_AW   = 6,
    parameter int       CAP_DW   = 16,
    parameter bit [7:0] CAP_ID   = 8'h0C,
    parameter bit [7:0] NEXT_PTR = 8'h00,
    parameter int       SEL_W    = 8,
    parameter int       RF_BYTES = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CFG_AW-1:0]   cfg_wr_addr,
    input  logic [3:0]          cfg_wr_be,
    input  logic [31:0]         cfg_wr_data,
    input  logic [CFG_AW-1:0]   cfg_rd_addr,
    output logic [31:0]         cfg_rd_data,
    output logic                busy,
    output logic                rf_wr_en,
    output logic                rf_rd_en,
    output logic [SEL_W+1:0]    rf_addr,
    output logic [3:0]          rf_wr_be,
    output logic [31:0]         rf_wr_data,
    input  logic [31:0]         rf_rd_data
);
    localparam logic [CFG_AW-1:0] HDR_IDX  = CFG_AW'(CAP_DW);
    localparam logic [CFG_AW-1:0] DATA_IDX = CFG_AW'(CAP_DW + 1);

    logic                wr_hit, data_hit, accept;
    logic                in_range, load_en, zero_en;
    logic [DW_BYTES-1:0] lane_ok;
    logic [SEL_W-1:0]    sel_q;
    logic [31:0]         data_q;

    assign data_hit = (cfg_wr_addr == DATA_IDX);
    assign wr_hit   = cfg_wr_en && (cfg_wr_be != '0) &&
                      ((cfg_wr_addr == HDR_IDX) || data_hit);
    assign accept   = wr_hit && !busy;

    iwin_range #(
        .SEL_W    (SEL_W),
        .RF_BYTES (RF_BYTES)
    ) u_range (
        .sel       (sel_q),
        .byte_addr (rf_addr),
        .in_range  (in_range),
        .lane_ok   (lane_ok)
    );

    iwin_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .data_hit (data_hit),
        .in_range (in_range),
        .busy     (busy),
        .rf_wr_en (rf_wr_en),
        .rf_rd_en (rf_rd_en),
        .load_en  (load_en),
        .zero_en  (zero_en)
    );

    iwin_regs #(
        .SEL_W    (SEL_W),
        .CFG_AW   (CFG_AW),
        .CAP_DW   (CAP_DW),
        .CAP_ID   (CAP_ID),
        .NEXT_PTR (NEXT_PTR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (cfg_wr_en),
        .wr_hit     (wr_hit),
        .busy       (busy),
        .accept     (accept),
        .wr_data_dw (data_hit),
        .wr_be      (cfg_wr_be),
        .wr_data    (cfg_wr_data),
        .load_en    (load_en),
        .zero_en    (zero_en),
        .load_word  (rf_rd_data),
        .lane_ok    (lane_ok),
        .rd_addr    (cfg_rd_addr),
        .rd_data    (cfg_rd_data),
        .sel_q      (sel_q),
        .data_q     (data_q)
    );

    assign rf_wr_be   = lane_ok;
    assign rf_wr_data = data_q;

    assert_rd_after_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> rf_rd_en);

    assert_wr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (int'(rf_addr) < RF_BYTES));

    assert_rd_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> (int'(rf_addr) < RF_BYTES));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && rf_rd_en));

    assert_wr_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> rf_wr_be[0]);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rf_wr_en && !rf_rd_en));

endmodule

// File: tb/iwin_dword_window_bench.sv
module iwin_dword_window_bench;

    localparam int       CFG_AW   = 6;
    localparam int       CAP_DW   = 16;
    localparam bit [7:0] CAP_ID   = 8'h0C;
    localparam bit [7:0] NEXT_PTR = 8'h00;
    localparam int       SEL_W    = 8;
    localparam int       RF_BYTES = 150;
    localparam int       SC_BYTE  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [CFG_AW-1:0] cfg_wr_addr = '0;
    logic [3:0]        cfg_wr_be = '0;
    logic [31:0]       cfg_wr_data = '0;
    logic [CFG_AW-1:0] cfg_rd_addr = '0;
    logic [31:0]       cfg_rd_data;
    logic              busy, rf_wr_en, rf_rd_en;
    logic [SEL_W+1:0]  rf_addr;
    logic [3:0]        rf_wr_be;
    logic [31:0]       rf_wr_data;
    logic [31:0]       rf_rd_data = '0;

    int tests = 0;
    int fails = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit done = 1'b0;
    logic [7:0] mem [0:255];

    always #4 clk = ~clk;

    iwin_dword_window #(
        .CFG_AW (CFG_AW), .CAP_DW (CAP_DW), .CAP_ID (CAP_ID),
        .NEXT_PTR (NEXT_PTR), .SEL_W (SEL_W), .RF_BYTES (RF_BYTES)
    ) u_iwin_dword_window (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_en (cfg_wr_en), .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_be (cfg_wr_be), .cfg_wr_data (cfg_wr_data),
        .cfg_rd_addr (cfg_rd_addr), .cfg_rd_data (cfg_rd_data),
        .busy (busy), .rf_wr_en (rf_wr_en), .rf_rd_en (rf_rd_en),
        .rf_addr (rf_addr), .rf_wr_be (rf_wr_be), .rf_wr_data (rf_wr_data),
        .rf_rd_data (rf_rd_data)
    );

    // Register file model: one cycle read latency, a self-clearing bit 0 at SC_BYTE,
    // and filler 0xEE for bytes past the end of the file.
    always @(posedge clk) begin
        if (rf_wr_en) begin
            wr_cnt <= wr_cnt + 1;
            for (int i = 0; i < 4; i++) begin
                if (rf_wr_be[i] && (int'(rf_addr) + i < RF_BYTES)) begin
                    if (int'(rf_addr) + i == SC_BYTE)
                        mem[int'(rf_addr) + i] <= rf_wr_data[i*8 +: 8] & 8'hFE;
                    else
                        mem[int'(rf_addr) + i] <= rf_wr_data[i*8 +: 8];
                end
            end
        end
        if (rf_rd_en) begin
            rd_cnt <= rd_cnt + 1;
            for (int i = 0; i < 4; i++)
                rf_rd_data[i*8 +: 8] <= (int'(rf_addr) + i < RF_BYTES) ?
                                        mem[int'(rf_addr) + i] : 8'hEE;
        end
    end

    function automatic logic [31:0] model_word(input int sel);
        logic [31:0] w;
        for (int i = 0; i < 4; i++)
            w[i*8 +: 8] = (sel*4 + i < RF_BYTES) ? mem[sel*4 + i] : 8'h00;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_read(input int idx, output logic [31:0] val);
        cfg_rd_addr = CFG_AW'(idx);
        #1;
        val = cfg_rd_data;
    endtask

    // Issues one write; returns at the negedge following the accepting edge.
    task automatic cfg_write(input int idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = CFG_AW'(idx); cfg_wr_be = be; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_be = '0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 20 && busy; n++) @(negedge clk);
        check("R10 busy falls", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 strobes", {30'd0, rf_wr_en, rf_rd_en}, 32'd0);
        cfg_read(CAP_DW, v);
        check("R1 header", v, {8'h00, 8'h00, NEXT_PTR, CAP_ID});
        cfg_read(CAP_DW + 1, v);
        check("R1 data", v, 32'd0);
    endtask

    task automatic t_read_only();
        logic [31:0] v;
        int w0 = wr_cnt;
        cfg_write(CAP_DW, 4'b1011, 32'hFFFF_FFFF);
        wait_idle();
        cfg_read(CAP_DW, v);
        check("R2 id/next/status read-only", v, {8'h00, 8'h00, NEXT_PTR, CAP_ID});
        check("R6 header write no rf write", 32'(wr_cnt - w0), 32'd0);
        cfg_read(CAP_DW + 1, v);
        check("R6 refresh at select 0", v, model_word(0));
    endtask

    task automatic t_select();
        logic [31:0] v;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        cfg_write(CAP_DW, 4'b0100, 32'h0007_0000);
        check("R6 read strobe next cycle", 32'(rf_rd_en), 32'd1);
        check("R6 no write strobe", 32'(rf_wr_en), 32'd0);
        check("R3 rf address", 32'(rf_addr), 32'd28);
        wait_idle();
        cfg_read(CAP_DW, v);
        check("R3 select readback", v, {8'h00, 8'h07, NEXT_PTR, CAP_ID});
        check("R6 write count", 32'(wr_cnt - w0), 32'd0);
        check("R6 read count", 32'(rd_cnt - r0), 32'd1);
        cfg_read(CAP_DW + 1, v);
        check("R6 mirror select 7", v, model_word(7));
    endtask

    task automatic t_forward();
        logic [31:0] v;
        cfg_write(CAP_DW, 4'b0100, 32'h0009_0000);
        wait_idle();
        cfg_write(CAP_DW + 1, 4'b1111, 32'h1234_5678);
        check("R4 write strobe", 32'(rf_wr_en), 32'd1);
        check("R4 write address", 32'(rf_addr), 32'd36);
        check("R4 write data", rf_wr_data, 32'h1234_5678);
        check("R4 write lanes", 32'(rf_wr_be), 32'hF);
        @(negedge clk);
        check("R5 read follows write", 32'(rf_rd_en), 32'd1);
        wait_idle();
        cfg_read(CAP_DW + 1, v);
        check("R5 mirror after forward", v, 32'h1234_5678);
        cfg_write(CAP_DW + 1, 4'b0010, 32'h0000_AB00);
        check("R4 byte merge forwarded", rf_wr_data, 32'h1234_AB78);
        wait_idle();
    endtask

    task automatic t_side_effect();
        logic [31:0] v;
        cfg_write(CAP_DW, 4'b0100, 32'h0005_0000);
        wait_idle();
        cfg_write(CAP_DW + 1, 4'b1111, 32'h0000_00FF);
        wait_idle();
        cfg_read(CAP_DW + 1, v);
        check("R5 mirror shows self-clear", v, 32'h0000_00FE);
    endtask

    task automatic t_ignored();
        logic [31:0] v, h;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        cfg_read(CAP_DW + 1, v);
        cfg_write(CAP_DW + 2, 4'b1111, 32'hDEAD_BEEF);
        check("R7 other dword not busy", 32'(busy), 32'd0);
        cfg_write(CAP_DW, 4'b0000, 32'h00FF_0000);
        check("R7 zero enables not busy", 32'(busy), 32'd0);
        cfg_write(CAP_DW + 1, 4'b0000, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 no strobes", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
        cfg_read(CAP_DW, h);
        check("R7 select kept", h, {8'h00, 8'h05, NEXT_PTR, CAP_ID});
        cfg_read(CAP_DW + 1, h);
        check("R7 data kept", h, v);
    endtask

    task automatic t_busy_drop();
        logic [31:0] v;
        int r0 = rd_cnt;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = CFG_AW'(CAP_DW); cfg_wr_be = 4'b0100;
        cfg_wr_data = 32'h0003_0000;
        @(negedge clk);
        check("R10 busy after accept", 32'(busy), 32'd1);
        cfg_wr_data = 32'h000C_0000;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_be = '0;
        wait_idle();
        cfg_read(CAP_DW, v);
        check("R10 write during busy dropped", v, {8'h00, 8'h03, NEXT_PTR, CAP_ID});
        check("R10 single refresh", 32'(rd_cnt - r0), 32'd1);
        cfg_read(CAP_DW + 1, v);
        check("R10 mirror select 3", v, model_word(3));
    endtask

    task automatic t_clip();
        logic [31:0] v;
        cfg_write(CAP_DW, 4'b0100, 32'h0025_0000);
        wait_idle();
        cfg_write(CAP_DW + 1, 4'b1111, 32'hAABB_CCDD);
        check("R9 clipped lanes", 32'(rf_wr_be), 32'h3);
        wait_idle();
        cfg_read(CAP_DW + 1, v);
        check("R9 mirror past end is zero", v, 32'h0000_CCDD);
    endtask

    task automatic t_out_range();
        logic [31:0] v;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        cfg_write(CAP_DW, 4'b0100, 32'h0028_0000);
        wait_idle();
        cfg_read(CAP_DW + 1, v);
        check("R8 mirror zero past end", v, 32'd0);
        cfg_write(CAP_DW + 1, 4'b1111, 32'h5555_AAAA);
        wait_idle();
        cfg_read(CAP_DW + 1, v);
        check("R8 data zero after dropped write", v, 32'd0);
        check("R8 no rf strobes", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_only();
        t_select();
        t_forward();
        t_side_effect();
        t_ignored();
        t_busy_drop();
        t_clip();
        t_out_range();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule